// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is a binary counter built from identical four-bit stages joined in a ripple-free chain. Every stage changes state only on the rising clock edge. At each edge it performs exactly one of four operations. CLEAR forces zero. LOAD copies the parallel data input. COUNT adds one. HOLD keeps the value. The active-low clear beats the active-low load, and the load beats counting.

Counting needs two active-high enables. The first, `cnt_en`, goes to every stage. The second, `carry_en`, enters the lowest stage only. Each stage passes a carry to the next one, and that carry is high only when the stage's own carry input is high and its value is all ones. As a result, each upper stage advances once for every full turn of the stages below it. The last carry leaves the block as `carry_out`.

An optional modulus-shortening wrapper compares the whole count against a parameter value. On a match it asserts the internal clear, so the counter returns to zero on the edge after that value.

Top module: `cnt_casc_top`

## Requirements
- R1: The count changes only on a rising clock edge. Input changes between edges leave `count` unchanged.
- R2: CLEAR: when `clr_n` is 0 at an edge, `count` becomes 0 whatever `load_n`, `cnt_en`, `carry_en` and `din` are.
- R3: LOAD: when `clr_n` is 1 and `load_n` is 0 at an edge, `count` takes `din` whatever both enables are.
- R4: COUNT: when `clr_n`, `load_n`, `cnt_en` and `carry_en` are all 1 at an edge, `count` increases by one.
- R5: HOLD: when `clr_n` and `load_n` are 1 and either enable is 0 at an edge, `count` keeps its value.
- R6: Counting wraps from all ones to zero, with no saturation.
- R7: `carry_out` is combinational and equals 1 exactly when `carry_en` is 1 and `count` is all ones. `cnt_en` has no effect on it.
- R8: With STAGES chained stages, the 4*STAGES-bit count behaves as a single binary counter. An upper stage advances only on the edge where every lower stage goes from all ones to zero, and the value matches a reference model under random mixes of operations.
- R9: With TRUNC_EN set, a `count` equal to TRUNC_VAL is replaced by 0 at the next edge, regardless of `load_n` and both enables.
- R10: Bit 0 of `din` and of `count` is the least significant bit, and each stage k holds bits 4k+3 down to 4k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable shared by all stages |
| carry_en | input | 1 | Carry enable into the lowest stage; also gates `carry_out` |
| din | input | 4*STAGES | Parallel load data, bit 0 least significant |
| count | output | 4*STAGES | Counter value |
| carry_out | output | 1 | Terminal-count carry of the top stage |

## Verification
The assertions assume the counter has seen at least one clear before they apply, because no other path sets a known value. After that first clear, they assume every control input is at a defined level at each edge. They also assume TRUNC_VAL fits in the counter width. The stimulus opens with a clear and changes inputs only at falling edges. It drives every control with a definite 0 or 1, in directed sequences followed by weighted random sequences. The bench runs two instances on the same inputs, one plain and one with a shortened modulus, so the clear-on-match path is exercised against loads and holds as well as counting.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } stage_op_t;
endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
    import cnt_pkg::*;
(
    input  logic      clr_n,
    input  logic      load_n,
    input  logic      en_p,
    input  logic      en_t,
    output stage_op_t op
);
    // Fixed priority: clear, then load, then count, else hold
    always_comb begin
        if (!clr_n)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (en_p && en_t)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          load_n,
    input  logic          en_p,
    input  logic          en_t,
    input  logic [SW-1:0] din,
    output logic [SW-1:0] q,
    output logic          tc
);
    stage_op_t     op;
    logic [SW-1:0] q_next;

    cnt_op_decode u_dec (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .op     (op)
    );

    // Next-state selection per operation
    always_comb begin
        unique case (op)
            OP_CLEAR: q_next = '0;
            OP_LOAD:  q_next = din;
            OP_COUNT: q_next = q + SW'(1);
            OP_HOLD:  q_next = q;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        q <= q_next;
    end

    // Look-ahead carry: gated by the carry enable only
    assign tc = en_t & (&q);
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
    parameter int STAGES = 2,
    parameter int SW     = 4,
    localparam int W     = STAGES * SW
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         en_p,
    input  logic         en_t,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc
);
    logic [STAGES:0] carry;

    assign carry[0] = en_t;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        cnt_stage #(.SW(SW)) u_stage (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .en_p   (en_p),
            .en_t   (carry[k]),
            .din    (din[k*SW +: SW]),
            .q      (q[k*SW +: SW]),
            .tc     (carry[k+1])
        );
    end

    assign tc = carry[STAGES];
endmodule

// File: rtl/cnt_mod_clear.sv
module cnt_mod_clear #(
    parameter int           W         = 8,
    parameter bit           TRUNC_EN  = 1'b0,
    parameter logic [W-1:0] TRUNC_VAL = '0
) (
    input  logic [W-1:0] count,
    input  logic         clr_n_in,
    output logic         clr_n_out
);
    if (TRUNC_EN) begin : g_trunc
        // Match on the chosen count pulls the synchronous clear low
        assign clr_n_out = clr_n_in & ~(count == TRUNC_VAL);
    end else begin : g_pass
        logic unused_count;
        assign unused_count = ^count;
        assign clr_n_out    = clr_n_in;
    end
endmodule

// File: rtl/cnt_casc_top.sv
module cnt_casc_top #(
    parameter int                      STAGES    = 2,
    parameter int                      SW        = 4,
    parameter bit                      TRUNC_EN  = 1'b0,
    parameter logic [STAGES*SW-1:0]    TRUNC_VAL = '0
) (
    input  logic                   clk,
    input  logic                   clr_n,
    input  logic                   load_n,
    input  logic                   cnt_en,
    input  logic                   carry_en,
    input  logic [STAGES*SW-1:0]   din,
    output logic [STAGES*SW-1:0]   count,
    output logic                   carry_out
);
    localparam int W = STAGES * SW;

    logic clr_n_int;

    cnt_mod_clear #(
        .W         (W),
        .TRUNC_EN  (TRUNC_EN),
        .TRUNC_VAL (TRUNC_VAL)
    ) u_mod (
        .count     (count),
        .clr_n_in  (clr_n),
        .clr_n_out (clr_n_int)
    );

    cnt_chain #(
        .STAGES (STAGES),
        .SW     (SW)
    ) u_chain (
        .clk    (clk),
        .clr_n  (clr_n_int),
        .load_n (load_n),
        .en_p   (cnt_en),
        .en_t   (carry_en),
        .din    (din),
        .q      (count),
        .tc     (carry_out)
    );
endmodule

// File: rtl/cnt_casc_check.sv
module cnt_casc_check #(
    parameter int           W         = 8,
    parameter bit           TRUNC_EN  = 1'b0,
    parameter logic [W-1:0] TRUNC_VAL = '0
) (
    input logic         clk,
    input logic         clr_n,
    input logic         load_n,
    input logic         cnt_en,
    input logic         carry_en,
    input logic [W-1:0] din,
    input logic [W-1:0] count,
    input logic         carry_out
);
    // Armed once a clear has been applied; the count is unknown before that
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        armed <= armed | ~clr_n;
    end

    logic hit;
    assign hit = TRUNC_EN && (count == TRUNC_VAL);

    assert_clear_R2: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> count == '0);

    assert_load_R3: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && !load_n && !hit) |=> count == $past(din));

    // R6 wrap is covered by the width-cast increment
    assert_count_R4: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && cnt_en && carry_en && !hit) |=> count == W'($past(count) + W'(1)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && !(cnt_en && carry_en) && !hit) |=> $stable(count));

    assert_carry_R7: assert property (@(posedge clk) disable iff (!armed)
        1'b1 |-> carry_out == (carry_en && (&count)));

    assert_trunc_R9: assert property (@(posedge clk) disable iff (!armed)
        hit |=> count == '0);
endmodule

bind cnt_casc_top cnt_casc_check #(
    .W         (STAGES * SW),
    .TRUNC_EN  (TRUNC_EN),
    .TRUNC_VAL (TRUNC_VAL)
) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .cnt_en    (cnt_en),
    .carry_en  (carry_en),
    .din       (din),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/cnt_casc_top_test.sv
`timescale 1ns/1ps
module cnt_casc_top_test;
    localparam int MODV = 199;

    logic       clk = 1'b0;
    logic       clr_n = 1'b1, load_n = 1'b1, cnt_en = 1'b0, carry_en = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] count, count_m;
    logic       carry_out, carry_out_m;

    int vectors = 0;
    int miscompares = 0;
    int m_plain = 0;
    int m_mod = 0;

    always #5 clk = ~clk;

    cnt_casc_top #(.STAGES(2), .SW(4)) uut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .carry_en(carry_en), .din(din), .count(count), .carry_out(carry_out)
    );

    cnt_casc_top #(.STAGES(2), .SW(4), .TRUNC_EN(1'b1), .TRUNC_VAL(8'(MODV))) uut_mod (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .carry_en(carry_en), .din(din), .count(count_m), .carry_out(carry_out_m)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ref_next(int cur, bit trunc, bit c, bit l, bit e, bit t, int d);
        if (!c || (trunc && cur == MODV)) return 0;
        if (!l) return d;
        if (e && t) return (cur + 1) % 256;
        return cur;
    endfunction

    // Apply one cycle of inputs (called just after a falling edge)
    task automatic step(input string req, input bit c, input bit l, input bit e,
                        input bit t, input logic [7:0] d);
        clr_n = c; load_n = l; cnt_en = e; carry_en = t; din = d;
        #1;
        chk({req, "/R7 carry"}, int'(carry_out), int'(t && m_plain == 255));
        chk({req, "/R7 carry mod"}, int'(carry_out_m), int'(t && m_mod == 255));
        m_plain = ref_next(m_plain, 1'b0, c, l, e, t, int'(d));
        m_mod   = ref_next(m_mod, 1'b1, c, l, e, t, int'(d));
        @(posedge clk);
        @(negedge clk);
        chk({req, " count"}, int'(count), m_plain);
        chk({req, " count mod"}, int'(count_m), m_mod);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R2: reset state, clear beats load and both enables
        step("R2", 1'b0, 1'b0, 1'b1, 1'b1, 8'hAA);
        // R3 and R10: load beats counting; bit 0 is the LSB
        step("R3", 1'b1, 1'b0, 1'b1, 1'b1, 8'h5A);
        step("R10", 1'b1, 1'b0, 1'b0, 1'b0, 8'h01);
        chk("R10 lsb", int'(count[0]), 1);
        // R4: counting
        for (int i = 0; i < 3; i++) step("R4", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        // R5: hold when either enable is low
        step("R5", 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF);
        step("R5", 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF);
        // R1: mid-cycle input change does not move the count
        clr_n = 1'b0; load_n = 1'b0; din = 8'h77;
        #2;
        chk("R1 between edges", int'(count), m_plain);
        step("R1", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        // R7 and R6: terminal count and wrap
        step("R7", 1'b1, 1'b0, 1'b0, 1'b0, 8'hFE);
        step("R4", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        step("R7 cnt_en low", 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
        step("R7 carry_en low", 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        step("R6", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        chk("R6 wrap", int'(count), 0);
        // R8: upper stage advances on lower stage rollover only
        step("R8", 1'b1, 1'b0, 1'b0, 1'b0, 8'h0F);
        step("R8", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        chk("R8 upper", int'(count[7:4]), 1);
        for (int i = 0; i < 16; i++) step("R8", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        chk("R8 upper once", int'(count[7:4]), 2);
        // R9: shortened modulus clears after the match, over hold and load
        step("R9", 1'b1, 1'b0, 1'b0, 1'b0, 8'(MODV - 1));
        step("R9", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        step("R9 hold", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R9 mod zero", int'(count_m), 0);
        step("R9", 1'b1, 1'b0, 1'b0, 1'b0, 8'(MODV));
        step("R9 load", 1'b1, 1'b0, 1'b1, 1'b1, 8'h33);
        chk("R9 plain loaded", int'(count), 8'h33);
        // R8: random mix against the reference model
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            bit c = (r >= 3);
            bit l = !(r >= 3 && r < 10);
            step("R8 random", c, l, ($urandom_range(0, 9) != 0),
                 ($urandom_range(0, 9) != 0), 8'($urandom_range(0, 255)));
        end
        finish_run();
    end
endmodule